// File: doc/BRIEF.md
# Serial Memory Slave Front End

This block is the serial side of a byte-wide memory device that always acts as an SPI slave (clock mode 0). The chip-select, serial clock, data-in, pause and write-protect pins are brought into the core clock domain through synchronizers. The block then decodes a command byte, an optional 16-bit address and data bytes, and drives serial data out with a separate output-enable that acts as the tristate control. Behind the shifter sits a small register file that stands in for the array, a status byte and a busy counter that models the internal write time.

A transfer starts when chip select falls. The first byte is the command. Reads return array bytes from an address that counts up, or the live status byte. Writes to the array or to the status byte are collected while the device is selected. They are committed only when chip select rises, and only if the write-enable latch is set and a whole number of bytes arrived. Each commit raises a one-cycle start pulse and then holds the device busy for a fixed number of core cycles. The pause pin and the write-protect pin are described in the requirements below.

The serial pins carry no valid/ready flow control. The master owns the clock, so there is no back-pressure. Its only way to stall is the pause pin, and the block never stalls the master.

Top module: `spi_ee_slave`

## Requirements
- R1: Data moves most significant bit first on both lines. The data-in line is sampled on rising serial clock edges. A new output bit is presented after each rising edge, in time for the next one.
- R2: While chip select is high, the output enable stays 0 and the data-in line and serial clock have no effect. Each falling edge of chip select restarts decoding at the command byte.
- R3: Command codes are: enable-write 0x06, disable-write 0x04, read-status 0x05, write-status 0x01, read 0x03, write 0x02. The read command, followed by a 16-bit address, returns the byte stored at that address (modulo the array size) and then the bytes at the following addresses.
- R4: Any other command code turns the output enable off and stops all decoding until the next falling edge of chip select. Valid codes sent later in the same selection have no effect.
- R5: The pause pin takes hold only when it falls while the serial clock is low. It releases only when it rises while the serial clock is low. While paused, the output enable is 0 and clock edges and data-in are ignored, but the bit position is kept. A pause edge that occurs while the clock is high has no effect.
- R6: The enable-write command sets the write-enable latch, which is status bit 1. The disable-write command clears it.
- R7: The read-status command returns the byte {protect-enable at bit 7, zeros in bits 6..2, write-enable latch at bit 1, busy at bit 0}, repeated while clocking continues. The value after reset is 0x00.
- R8: A write or write-status command starts the internal cycle on the rising edge of chip select. This happens only if the latch is set, at least one data byte arrived, and no partial byte is pending. The start is marked by a single-cycle pulse on `wr_start`. In every other case nothing is stored.
- R9: Write-status stores data bit 7 as the protect-enable bit. When protect-enable is 1, a write-status is rejected if the protect pin is low at chip-select rise or was low at any moment during the selection. Once the cycle has started, the protect pin no longer matters. When protect-enable is 0, the protect pin is ignored.
- R10: After a start, busy reads 1 for `WRITE_CYCLES` core cycles. During that time, every command except read-status locks the selection as in R4. The latch clears when the cycle ends.
- R11: Write data bytes are stored at consecutive addresses from the given one. Up to `PAGE_BYTES` bytes are kept, and later bytes reuse the earliest slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Write protect, active low |
| so | output | 1 | Serial data out (0 while not enabled) |
| so_oe | output | 1 | Output enable for the serial data pad |
| wr_start | output | 1 | One-cycle pulse when an internal write cycle begins |

## Verification
Every pin passes through two synchronizer flops plus an edge register. A rising clock edge therefore reaches the shift state about three core cycles later, and an output bit changes about four cycles after that edge. The bench holds each clock phase for eight core cycles and samples the output just before it raises the clock, so each bit is read well after it has settled. `wr_start` appears about four cycles after chip select rises. Busy then lasts `WRITE_CYCLES` cycles, so array and status results are checked by a later read only after waiting that long plus a margin. Pause and protect effects are sampled at least one clock phase after the pin edge that causes them.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_RD, ST_SR, ST_WD, ST_WSR, ST_DONE, ST_LOCK
  } st_e;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  // pin vector order: [4] cs_n, [3] sck, [2] si, [1] hold_n, [0] wp_n
  localparam int PIN_N = 5;
  localparam logic [PIN_N-1:0] PIN_IDLE = 5'b10011;
endpackage

// File: rtl/spi_ee_pins.sv
module spi_ee_pins
  import spi_ee_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_N-1:0] raw,
  output logic [PIN_N-1:0] now,
  output logic [PIN_N-1:0] rise,
  output logic [PIN_N-1:0] fall
);
  logic [PIN_N-1:0] stg [STAGES];
  logic [PIN_N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= PIN_IDLE;
      prev <= PIN_IDLE;
    end else begin
      stg[0] <= raw;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign now  = stg[STAGES-1];
  assign rise = now & ~prev;
  assign fall = ~now & prev;
endmodule

// File: rtl/spi_ee_store.sv
module spi_ee_store #(
  parameter int AW         = 8,
  parameter int PAGE_BYTES = 4,
  parameter int WCYC       = 600
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          buf_clear,
  input  logic          buf_push,
  input  logic [7:0]    push_data,
  input  logic          start_arr,
  input  logic          start_sr,
  input  logic [7:0]    sr_data,
  input  logic          wel_set,
  input  logic          wel_clr,
  output logic [7:0]    status
);
  localparam int BW    = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
  localparam int CW    = $clog2(WCYC + 1);
  localparam int DEPTH = 1 << AW;

  logic [7:0]    mem  [DEPTH];
  logic [7:0]    pbuf [PAGE_BYTES];
  logic [AW-1:0] base;
  logic [BW:0]   cnt, widx;
  logic [BW-1:0] pidx;
  logic [CW-1:0] bcnt;
  logic          wpen, wel, busy;

  assign busy    = (bcnt != '0);
  assign status  = {wpen, 5'b0, wel, busy};
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0; cnt <= '0; widx <= '0; pidx <= '0;
      bcnt <= '0; wpen <= 1'b0; wel <= 1'b0;
    end else begin
      if (buf_clear) begin
        base <= rd_addr; cnt <= '0; pidx <= '0;
      end else if (buf_push) begin
        pidx <= pidx + 1'b1;
        if (cnt != (BW+1)'(PAGE_BYTES)) cnt <= cnt + 1'b1;
      end
      if (wel_set) wel <= 1'b1;
      else if (wel_clr) wel <= 1'b0;
      if (start_arr) begin
        bcnt <= CW'(WCYC); widx <= '0;
      end else if (start_sr) begin
        bcnt <= CW'(WCYC); widx <= cnt; wpen <= sr_data[7];
      end else if (busy) begin
        bcnt <= bcnt - 1'b1;
        if (bcnt == CW'(1)) wel <= 1'b0;
        if (widx < cnt) widx <= widx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (buf_push) pbuf[pidx] <= push_data;
    if (busy && !start_sr && widx < cnt)
      mem[base + AW'(widx)] <= pbuf[widx[BW-1:0]];
  end
endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
  import spi_ee_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          cs_fall,
  input  logic          cs_rise,
  input  logic          sck_s,
  input  logic          sck_rise,
  input  logic          si_s,
  input  logic          hold_fall,
  input  logic          hold_rise,
  input  logic          wp_s,
  input  logic [7:0]    status,
  input  logic [7:0]    rd_data,
  output logic          so,
  output logic          so_oe,
  output logic          paused,
  output logic          locked,
  output logic [AW-1:0] rd_addr,
  output logic          buf_clear,
  output logic          buf_push,
  output logic [7:0]    push_data,
  output logic          start_arr,
  output logic          start_sr,
  output logic [7:0]    sr_data,
  output logic          wel_set,
  output logic          wel_clr
);
  st_e         st;
  logic [2:0]  bitc;
  logic [6:0]  sh;
  logic [15:0] addr;
  logic        hi_done, is_rd, got_byte, blk;
  logic        busy, wel, wpen, active, edge_ok, byte_end;
  logic [7:0]  in_byte, out_b;

  assign busy     = status[0];
  assign wel      = status[1];
  assign wpen     = status[7];
  assign active   = !cs_s && !paused &&
                    (st inside {ST_OPC, ST_ADDR, ST_RD, ST_SR, ST_WD, ST_WSR});
  assign edge_ok  = active && sck_rise;
  assign in_byte  = {sh, si_s};
  assign byte_end = edge_ok && (bitc == 3'd7);
  assign rd_addr  = addr[AW-1:0];
  assign locked   = (st == ST_LOCK);
  assign so_oe    = !cs_s && !paused && (st == ST_RD || st == ST_SR);
  assign out_b    = (st == ST_SR) ? status : rd_data;
  assign so       = so_oe & out_b[~bitc];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bitc <= '0; sh <= '0; addr <= '0;
      hi_done <= 1'b0; is_rd <= 1'b0; got_byte <= 1'b0; blk <= 1'b0;
      paused <= 1'b0; sr_data <= '0; push_data <= '0;
      buf_clear <= 1'b0; buf_push <= 1'b0; start_arr <= 1'b0;
      start_sr <= 1'b0; wel_set <= 1'b0; wel_clr <= 1'b0;
    end else begin
      buf_clear <= 1'b0; buf_push <= 1'b0; start_arr <= 1'b0;
      start_sr <= 1'b0; wel_set <= 1'b0; wel_clr <= 1'b0;
      if (cs_fall) begin
        st <= ST_OPC; bitc <= '0; paused <= 1'b0;
        hi_done <= 1'b0; got_byte <= 1'b0; blk <= 1'b0;
      end else if (cs_rise) begin
        if (st == ST_WD && wel && !busy && bitc == 3'd0 && got_byte)
          start_arr <= 1'b1;
        if (st == ST_WSR && wel && !busy && bitc == 3'd0 && got_byte &&
            !blk && !(wpen && !wp_s))
          start_sr <= 1'b1;
        st <= ST_IDLE; paused <= 1'b0;
      end else if (!cs_s) begin
        if (wpen && !wp_s) blk <= 1'b1;
        if (hold_fall && !sck_s) paused <= 1'b1;
        else if (hold_rise && !sck_s) paused <= 1'b0;
        if (edge_ok) begin
          sh   <= in_byte[6:0];
          bitc <= bitc + 3'd1;
        end
        if (byte_end) begin
          unique case (st)
            ST_OPC: begin
              if (busy && in_byte != OP_RDSR) st <= ST_LOCK;
              else begin
                case (in_byte)
                  OP_WREN:  begin wel_set <= 1'b1; st <= ST_DONE; end
                  OP_WRDI:  begin wel_clr <= 1'b1; st <= ST_DONE; end
                  OP_RDSR:  st <= ST_SR;
                  OP_WRSR:  st <= ST_WSR;
                  OP_READ:  begin is_rd <= 1'b1; st <= ST_ADDR; end
                  OP_WRITE: begin is_rd <= 1'b0; st <= ST_ADDR; end
                  default:  st <= ST_LOCK;
                endcase
              end
            end
            ST_ADDR: begin
              if (!hi_done) begin
                addr[15:8] <= in_byte; hi_done <= 1'b1;
              end else begin
                addr[7:0] <= in_byte;
                if (is_rd) st <= ST_RD;
                else begin st <= ST_WD; buf_clear <= 1'b1; end
              end
            end
            ST_RD:  addr <= addr + 16'd1;
            ST_WD:  begin buf_push <= 1'b1; push_data <= in_byte; got_byte <= 1'b1; end
            ST_WSR: begin sr_data <= in_byte; got_byte <= 1'b1; end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/spi_ee_slave.sv
module spi_ee_slave
  import spi_ee_pkg::*;
#(
  parameter int ADDR_BITS    = 8,
  parameter int PAGE_BYTES   = 4,
  parameter int WRITE_CYCLES = 600,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe,
  output logic wr_start
);
  logic [PIN_N-1:0]     pin_now, pin_rise, pin_fall;
  logic [ADDR_BITS-1:0] rd_addr;
  logic [7:0]           rd_data, status, push_data, sr_data;
  logic                 buf_clear, buf_push, start_arr, start_sr, wel_set, wel_clr;
  logic                 paused, locked, cs_s, busy, wel;

  spi_ee_pins #(.STAGES(SYNC_STAGES)) u_pins (
    .clk(clk), .rst_n(rst_n), .raw({cs_n, sck, si, hold_n, wp_n}),
    .now(pin_now), .rise(pin_rise), .fall(pin_fall)
  );

  assign cs_s     = pin_now[4];
  assign busy     = status[0];
  assign wel      = status[1];
  assign wr_start = start_arr | start_sr;

  spi_ee_ctrl #(.AW(ADDR_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cs_s(cs_s), .cs_fall(pin_fall[4]), .cs_rise(pin_rise[4]),
    .sck_s(pin_now[3]), .sck_rise(pin_rise[3]), .si_s(pin_now[2]),
    .hold_fall(pin_fall[1]), .hold_rise(pin_rise[1]), .wp_s(pin_now[0]),
    .status(status), .rd_data(rd_data), .so(so), .so_oe(so_oe),
    .paused(paused), .locked(locked), .rd_addr(rd_addr),
    .buf_clear(buf_clear), .buf_push(buf_push), .push_data(push_data),
    .start_arr(start_arr), .start_sr(start_sr), .sr_data(sr_data),
    .wel_set(wel_set), .wel_clr(wel_clr)
  );

  spi_ee_store #(.AW(ADDR_BITS), .PAGE_BYTES(PAGE_BYTES), .WCYC(WRITE_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .buf_clear(buf_clear), .buf_push(buf_push), .push_data(push_data),
    .start_arr(start_arr), .start_sr(start_sr), .sr_data(sr_data),
    .wel_set(wel_set), .wel_clr(wel_clr), .status(status)
  );
endmodule

// File: rtl/spi_ee_checker.sv
module spi_ee_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic so_oe,
  input logic paused,
  input logic locked,
  input logic wr_start,
  input logic busy,
  input logic wel
);
  // R2: no drive while deselected
  a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |-> !so_oe);
  // R5: no drive while paused
  a_r5_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !so_oe);
  // R4: no drive after an unknown command
  a_r4_lock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !so_oe);
  // R8: start only when deselected, enabled and idle
  a_r8_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> (cs_s && wel && !busy));
  // R10: busy follows a start
  a_r10_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> busy);
  // R8: start is a single-cycle pulse
  a_r8_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !wr_start);
endmodule

bind spi_ee_slave spi_ee_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .so_oe(so_oe), .paused(paused),
  .locked(locked), .wr_start(wr_start), .busy(busy), .wel(wel)
);

// File: tb/tb_spi_ee_slave.sv
`timescale 1ns/1ps
module tb_spi_ee_slave;
  localparam int HP   = 8;
  localparam int WCYC = 600;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_oe, wr_start;
  int   n_chk = 0, n_fail = 0, n_start = 0, exp_start = 0;
  logic oe_seen, done = 1'b0;

  always #2 clk = ~clk;

  spi_ee_slave #(.WRITE_CYCLES(WCYC)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe), .wr_start(wr_start)
  );

  always @(posedge clk) if (rst_n && wr_start) n_start++;

  // {address, data} pairs written then read back
  localparam logic [23:0] VEC [4] = '{
    {16'h0010, 8'hA5}, {16'h00FF, 8'h3C}, {16'h1200, 8'h81}, {16'h0001, 8'h7E}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    @(negedge clk); cs_n = 1'b0; oe_seen = 1'b0; wait_clk(HP);
  endtask

  task automatic desel();
    wait_clk(HP); cs_n = 1'b1; wait_clk(2 * HP);
  endtask

  task automatic bit_io(input logic b, output logic r);
    si = b; wait_clk(HP);
    r = so; oe_seen = oe_seen | so_oe;
    sck = 1'b1; wait_clk(HP); sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) bit_io(tx[i], rx[i]);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d;
    sel(); xfer(op, d); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    sel(); xfer(8'h05, d); xfer(8'h00, s); desel();
  endtask

  task automatic write1(input logic [15:0] a, input logic [7:0] v);
    logic [7:0] d;
    sel(); xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d); xfer(v, d); desel();
  endtask

  task automatic read1(input logic [15:0] a, output logic [7:0] v);
    logic [7:0] d;
    sel(); xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d); xfer(8'h00, v); desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    sel(); xfer(8'h01, d); xfer(v, d); desel();
  endtask

  initial begin
    logic [7:0] d, s, v;
    logic r;
    wait_clk(5); rst_n = 1'b1; wait_clk(5);

    // reset state
    check("R2 reset oe", {15'b0, so_oe}, 16'h0);
    rdsr(s); check("R7 reset status", {8'h0, s}, 16'h0000);

    // table of single-byte writes and reads
    foreach (VEC[i]) begin
      cmd(8'h06);
      write1(VEC[i][23:8], VEC[i][7:0]); exp_start++;
      wait_clk(WCYC + 40);
      read1(VEC[i][23:8], v);
      check("R3 R11 R1 readback", {8'h0, v}, {8'h0, VEC[i][7:0]});
    end

    // sequential multi-byte write and read
    cmd(8'h06);
    sel(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h80, d);
    xfer(8'h01, d); xfer(8'h02, d); xfer(8'h03, d); desel(); exp_start++;
    wait_clk(WCYC + 40);
    sel(); xfer(8'h03, d); xfer(8'h00, d); xfer(8'h80, d);
    for (int k = 1; k <= 3; k++) begin
      xfer(8'h00, v); check("R11 R3 sequential", {8'h0, v}, 16'(k));
    end
    desel();

    // R6 latch set and clear
    cmd(8'h06); rdsr(s); check("R6 enable sets bit1", {8'h0, s}, 16'h0002);
    cmd(8'h04); rdsr(s); check("R6 disable clears bit1", {8'h0, s}, 16'h0000);

    // R8 write without latch, and a partial byte
    write1(16'h0010, 8'h00);
    cmd(8'h06);
    sel(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h10, d); xfer(8'h22, d);
    for (int k = 0; k < 4; k++) bit_io(1'b1, r);
    desel(); wait_clk(WCYC + 40);
    read1(16'h0010, v); check("R8 rejected writes leave data", {8'h0, v}, 16'h00A5);
    rdsr(s); check("R8 latch kept without cycle", {8'h0, s}, 16'h0002);
    cmd(8'h04);

    // R2 deselected clocking ignored
    oe_seen = 1'b0;
    for (int k = 0; k < 8; k++) bit_io(1'b1, r);
    check("R2 no drive deselected", {15'b0, oe_seen}, 16'h0);
    rdsr(s); check("R2 state after idle clocks", {8'h0, s}, 16'h0000);

    // R4 unknown command locks the selection
    sel(); xfer(8'hAB, d); xfer(8'h05, d); xfer(8'h00, d); desel();
    check("R4 locked no drive", {15'b0, oe_seen}, 16'h0);
    rdsr(s); check("R4 next selection works", {8'h0, s}, 16'h0000);

    // R5 pause during a read
    cmd(8'h06); write1(16'h0040, 8'hC3); exp_start++; wait_clk(WCYC + 40);
    sel(); xfer(8'h03, d); xfer(8'h00, d); xfer(8'h40, d);
    for (int k = 7; k >= 5; k--) begin bit_io(1'b0, r); v[k] = r; end
    hold_n = 1'b0; wait_clk(HP);
    check("R5 paused no drive", {15'b0, so_oe}, 16'h0);
    for (int k = 0; k < 4; k++) begin
      si = k[0]; sck = 1'b1; wait_clk(HP); sck = 1'b0; wait_clk(HP);
    end
    hold_n = 1'b1; wait_clk(HP);
    for (int k = 4; k >= 0; k--) begin bit_io(1'b0, r); v[k] = r; end
    desel();
    check("R5 position kept across pause", {8'h0, v}, 16'h00C3);

    // R5 pause edge with clock high has no effect
    sel(); xfer(8'h03, d); xfer(8'h00, d); xfer(8'h40, d);
    si = 1'b0; wait_clk(HP); v[7] = so;
    sck = 1'b1; wait_clk(HP / 2); hold_n = 1'b0; wait_clk(HP / 2); sck = 1'b0;
    wait_clk(HP);
    check("R5 clock-high pause ignored", {15'b0, so_oe}, 16'h1);
    hold_n = 1'b1;
    for (int k = 6; k >= 0; k--) begin bit_io(1'b0, r); v[k] = r; end
    desel();
    check("R5 data after ignored pause", {8'h0, v}, 16'h00C3);

    // R10 busy window
    cmd(8'h06); write1(16'h0050, 8'h11); exp_start++;
    rdsr(s); check("R10 busy and latch during cycle", {8'h0, s}, 16'h0003);
    sel(); xfer(8'h03, d); xfer(8'h00, d); xfer(8'h50, d); desel();
    check("R10 read locked while busy", {15'b0, oe_seen}, 16'h0);
    wait_clk(WCYC + 40);
    rdsr(s); check("R10 latch cleared after cycle", {8'h0, s}, 16'h0000);
    read1(16'h0050, v); check("R10 data stored", {8'h0, v}, 16'h0011);

    // R9 status write and protect
    cmd(8'h06); wrsr(8'h80); exp_start++; wait_clk(WCYC + 40);
    rdsr(s); check("R9 protect-enable set", {8'h0, s}, 16'h0080);
    wp_n = 1'b0; cmd(8'h06); wrsr(8'h00); wait_clk(WCYC + 40);
    rdsr(s); check("R9 blocked with pin low", {8'h0, s}, 16'h0082);
    wp_n = 1'b1;
    sel(); xfer(8'h01, d); xfer(8'h00, d);
    wp_n = 1'b0; wait_clk(HP); wp_n = 1'b1; desel(); wait_clk(WCYC + 40);
    rdsr(s); check("R9 pin pulse during selection blocks", {8'h0, s}, 16'h0082);
    wrsr(8'h00); exp_start++; wait_clk(20);
    wp_n = 1'b0; wait_clk(WCYC + 40); wp_n = 1'b1;
    rdsr(s); check("R9 pin after start ignored", {8'h0, s}, 16'h0000);
    wp_n = 1'b0; cmd(8'h06); wrsr(8'h80); exp_start++; wait_clk(WCYC + 40);
    rdsr(s); check("R9 pin ignored when disabled", {8'h0, s}, 16'h0080);
    wp_n = 1'b1; cmd(8'h06); wrsr(8'h00); exp_start++; wait_clk(WCYC + 40);

    check("R8 start pulse count", 16'(n_start), 16'(exp_start));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule